// File: doc/BRIEF.md
# Load-Use Register Interlock Scoreboard

This block sits beside the issue stage of a simple in-order integer pipeline and keeps track of every register whose load data has not yet come back from memory. The instruction that is about to issue presents its two source registers, its destination register and, when it is a load, a latency code and a double-word flag. The block raises `stall` only when that instruction touches a register that is still waiting for its data, or when the loads already in flight leave no room in the address pipeline. Instructions that do not depend on an outstanding load keep issuing during the read latency. The wait cycles are inserted by hardware and software never sees them.

Each load picks its own way of being released. A non-zero latency code gives the number of cycles from the issue cycle to the first cycle in which the data can be used, and a per-register down-counter counts it out. A latency code of zero means the latency is not known at issue time: the register stays pending until a return strobe carries its number back. A double-word load fills an even/odd register pair as two back-to-back words. The odd register becomes available one cycle after the even one.

An instruction is issued in every cycle where `ins_valid` is high and `stall` is low. The issue logic holds a stalled instruction on the inputs unchanged until `stall` falls.

Top module: `lu_scoreboard`

## Requirements
- R1: After reset no register is pending, and with the bus idle `stall` is low for any valid non-load instruction, whatever registers it names.
- R2: A load with latency code L ≥ 1, issued in cycle T, makes its destination usable from cycle T+L. A dependent instruction presented at T+1 therefore stalls exactly L−1 cycles, and with L = 1 it never stalls.
- R3: An instruction that names no pending register, and is not a load blocked by R9, never stalls, even while other loads are outstanding.
- R4: `stall` is high in any cycle where `ins_valid` is high and `ins_src_a` or `ins_src_b` names a pending register.
- R5: `stall` is high in any cycle where `ins_valid` is high and the destination names a pending register. This keeps write-after-write order and holds back a second load to a register whose earlier load is still outstanding.
- R6: A load with latency code 0 leaves its destination pending until a cycle in which `ret_valid` is high and `ret_tag` equals that register. The register is free from the next cycle on.
- R7: A return strobe has no effect when its tag names a register that is not waiting for a tagged return. This covers registers that are idle and registers that are counting down a latency.
- R8: When `ins_pair` is set on a load, the destination with bit 0 cleared receives the first word with latency L, and the same register with bit 0 set receives the second word with latency L+1. In tag mode (L = 0) each register of the pair waits for its own return strobe.
- R9: A load stalls whenever the number of pending registers plus its word count (1, or 2 for a pair) exceeds `SLOTS`. The number of pending registers never exceeds `SLOTS`.
- R10: `stall` is low in every cycle where `ins_valid` is low.
- R11: A cycle with `stall` high records nothing. The pending state then evolves as if the held instruction had not been presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | An instruction is presented for issue |
| ins_load | input | 1 | The presented instruction is a load |
| ins_pair | input | 1 | The load writes an even/odd register pair |
| ins_src_a | input | $clog2(NREG) | First source register number |
| ins_src_b | input | $clog2(NREG) | Second source register number |
| ins_dst | input | $clog2(NREG) | Destination register number |
| ins_lat | input | LAT_W | Load latency in cycles; 0 selects release by return strobe |
| ret_valid | input | 1 | Tagged load data is written this cycle |
| ret_tag | input | $clog2(NREG) | Register number of the returning data |
| stall | output | 1 | Hold the presented instruction this cycle |

## Verification
The bench builds the block with eight registers, a three-bit latency code and two address slots. These values make every latency from 1 to 7, every tagged return delay, and slot exhaustion by single and paired loads small enough to sweep completely. Stall counts are predicted from the latency arithmetic. A long pseudo-random stream of loads, pairs, dependent instructions and stray return strobes is then compared cycle by cycle against a model of ready times kept in the bench.

// File: rtl/lus_pkg.sv
package lus_pkg;

   // How a pending register is released
   typedef enum logic {
      REL_COUNT = 1'b0,   // down-counter reaches zero
      REL_TAG   = 1'b1    // matching return strobe
   } rel_e;

   // Number of register words a load writes
   function automatic int unsigned words_of(input logic pair);
      return pair ? 32'd2 : 32'd1;
   endfunction

endpackage

// File: rtl/lus_entry.sv
module lus_entry
   import lus_pkg::*;
#(
   parameter int LAT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_i,
   input  rel_e             set_rel_i,
   input  logic [LAT_W-1:0] set_cnt_i,
   input  logic             ret_hit_i,
   output logic             busy_o,
   output logic             tag_o
);

   logic             tag_q;
   logic [LAT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_q <= 1'b0;
         cnt_q <= '0;
      end else if (set_i) begin
         tag_q <= (set_rel_i == REL_TAG);
         cnt_q <= (set_rel_i == REL_TAG) ? '0 : set_cnt_i;
      end else begin
         if (ret_hit_i && tag_q) begin
            tag_q <= 1'b0;
         end
         if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign busy_o = tag_q | (cnt_q != '0);
   assign tag_o  = tag_q;

endmodule

// File: rtl/lus_popcount.sv
module lus_popcount #(
   parameter int N  = 16,
   parameter int CW = $clog2(N + 1)
) (
   input  logic [N-1:0]  vec_i,
   output logic [CW-1:0] cnt_o
);

   always_comb begin
      cnt_o = '0;
      for (int i = 0; i < N; i++) begin
         cnt_o = cnt_o + CW'(vec_i[i]);
      end
   end

endmodule

// File: rtl/lus_hazard.sv
module lus_hazard #(
   parameter int NREG      = 16,
   parameter bit CHECK_DST = 1'b1,
   parameter int RW        = $clog2(NREG)
) (
   input  logic [NREG-1:0] busy_i,
   input  logic [RW-1:0]   src_a_i,
   input  logic [RW-1:0]   src_b_i,
   input  logic [RW-1:0]   w0_i,
   input  logic [RW-1:0]   w1_i,
   input  logic            pair_i,
   output logic            hz_o
);

   logic hz_src;
   logic hz_dst;

   assign hz_src = busy_i[src_a_i] | busy_i[src_b_i];

   generate
      if (CHECK_DST) begin : g_dst_check
         assign hz_dst = busy_i[w0_i] | (pair_i & busy_i[w1_i]);
      end else begin : g_dst_free
         assign hz_dst = 1'b0;
      end
   endgenerate

   assign hz_o = hz_src | hz_dst;

endmodule

// File: rtl/lu_scoreboard.sv
module lu_scoreboard
   import lus_pkg::*;
#(
   parameter int NREG      = 16,
   parameter int LAT_W     = 4,
   parameter int SLOTS     = 2,
   parameter bit CHECK_DST = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ins_valid,
   input  logic                    ins_load,
   input  logic                    ins_pair,
   input  logic [$clog2(NREG)-1:0] ins_src_a,
   input  logic [$clog2(NREG)-1:0] ins_src_b,
   input  logic [$clog2(NREG)-1:0] ins_dst,
   input  logic [LAT_W-1:0]        ins_lat,
   input  logic                    ret_valid,
   input  logic [$clog2(NREG)-1:0] ret_tag,
   output logic                    stall
);

   localparam int RW = $clog2(NREG);
   localparam int CW = $clog2(NREG + 1);

   // Elaboration-time parameter checks
   generate
      if (NREG < 4 || (1 << RW) != NREG) begin : g_bad_nreg
         $error("lu_scoreboard: NREG must be a power of two, at least 4");
      end
      if (LAT_W < 2) begin : g_bad_lat
         $error("lu_scoreboard: LAT_W must be at least 2");
      end
      if (SLOTS < 2 || SLOTS > NREG) begin : g_bad_slots
         $error("lu_scoreboard: SLOTS must lie in 2..NREG");
      end
   endgenerate

   logic [NREG-1:0]  busy;
   logic [NREG-1:0]  tag_pend;
   logic [CW-1:0]    occ;
   logic [RW-1:0]    w0;
   logic [RW-1:0]    w1;
   logic             is_tag;
   rel_e             rel;
   logic [LAT_W-1:0] cnt0;
   logic [LAT_W-1:0] cnt1;
   logic             hz;
   logic             slot_full;
   logic             issue;

   // Word addresses: a pair is forced onto an even/odd register couple
   assign w0 = ins_pair ? {ins_dst[RW-1:1], 1'b0} : ins_dst;
   assign w1 = {ins_dst[RW-1:1], 1'b1};

   assign is_tag = (ins_lat == '0);
   assign rel    = is_tag ? REL_TAG : REL_COUNT;
   assign cnt0   = is_tag ? '0 : ins_lat - 1'b1;
   assign cnt1   = is_tag ? '0 : ins_lat;

   lus_hazard #(
      .NREG      (NREG),
      .CHECK_DST (CHECK_DST),
      .RW        (RW)
   ) u_hazard (
      .busy_i  (busy),
      .src_a_i (ins_src_a),
      .src_b_i (ins_src_b),
      .w0_i    (w0),
      .w1_i    (w1),
      .pair_i  (ins_pair),
      .hz_o    (hz)
   );

   lus_popcount #(
      .N  (NREG),
      .CW (CW)
   ) u_occ (
      .vec_i (busy),
      .cnt_o (occ)
   );

   assign slot_full = ins_load &&
                      ((int'(occ) + int'(words_of(ins_pair))) > SLOTS);
   assign stall     = ins_valid & (hz | slot_full);
   assign issue     = ins_valid & ins_load & ~stall;

   generate
      for (genvar r = 0; r < NREG; r++) begin : g_reg
         localparam logic [RW-1:0] IDX = RW'(r);
         logic             set0;
         logic             set1;
         logic             set_any;
         logic [LAT_W-1:0] cnt_sel;
         logic             hit;

         assign set0    = issue && (w0 == IDX);
         assign set1    = issue && ins_pair && (w1 == IDX);
         assign set_any = set0 | set1;
         assign cnt_sel = set1 ? cnt1 : cnt0;
         assign hit     = ret_valid && (ret_tag == IDX);

         lus_entry #(
            .LAT_W (LAT_W)
         ) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (set_any),
            .set_rel_i (rel),
            .set_cnt_i (cnt_sel),
            .ret_hit_i (hit),
            .busy_o    (busy[r]),
            .tag_o     (tag_pend[r])
         );
      end
   endgenerate

endmodule

// File: rtl/lus_checker.sv
module lus_checker #(
   parameter int NREG  = 16,
   parameter int LAT_W = 4,
   parameter int SLOTS = 2,
   parameter int RW    = $clog2(NREG)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ins_valid,
   input logic             ins_load,
   input logic             ins_pair,
   input logic [RW-1:0]    ins_src_a,
   input logic [RW-1:0]    ins_src_b,
   input logic [LAT_W-1:0] ins_lat,
   input logic             ret_valid,
   input logic [RW-1:0]    ret_tag,
   input logic             stall,
   input logic [NREG-1:0]  busy,
   input logic [NREG-1:0]  tag_pend,
   input logic [RW-1:0]    w0
);

   logic issued;
   assign issued = ins_valid && ins_load && !stall;

   // R1: reset leaves nothing pending
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (busy == '0));

   // R2: single-word load with latency 1 is usable in the next cycle
   p_unit_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (issued && !ins_pair && ins_lat == LAT_W'(1)) |=> !busy[$past(w0)]);

   // R4: a pending source always holds the instruction
   p_src_a_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && busy[ins_src_a]) |-> stall);

   p_src_b_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && busy[ins_src_b]) |-> stall);

   // R5: a load never issues onto a pending register
   p_no_load_on_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      issued |-> !busy[w0]);

   // R6: a matching return frees a tag-pending register next cycle
   p_tag_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && tag_pend[ret_tag]) |=> !busy[$past(ret_tag)]);

   // R9: pending population bounded by the slot count
   p_slot_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(busy) <= SLOTS);

   // R10: no stall without an instruction
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ins_valid |-> !stall);

endmodule

bind lu_scoreboard lus_checker #(
   .NREG  (NREG),
   .LAT_W (LAT_W),
   .SLOTS (SLOTS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ins_valid (ins_valid),
   .ins_load  (ins_load),
   .ins_pair  (ins_pair),
   .ins_src_a (ins_src_a),
   .ins_src_b (ins_src_b),
   .ins_lat   (ins_lat),
   .ret_valid (ret_valid),
   .ret_tag   (ret_tag),
   .stall     (stall),
   .busy      (busy),
   .tag_pend  (tag_pend),
   .w0        (w0)
);

// File: tb/lu_scoreboard_tb.sv
`timescale 1ns/1ps
module lu_scoreboard_tb;

   localparam int NREG  = 8;
   localparam int LAT_W = 3;
   localparam int SLOTS = 2;
   localparam int RW    = $clog2(NREG);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ins_valid = 1'b0;
   logic             ins_load = 1'b0;
   logic             ins_pair = 1'b0;
   logic [RW-1:0]    ins_src_a = '0;
   logic [RW-1:0]    ins_src_b = '0;
   logic [RW-1:0]    ins_dst = '0;
   logic [LAT_W-1:0] ins_lat = '0;
   logic             ret_valid = 1'b0;
   logic [RW-1:0]    ret_tag = '0;
   logic             stall;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // Model: ready cycle per register, and tag-wait flag
   int rdy [NREG];
   bit tp  [NREG];
   int cyc = 0;

   always #2 clk = ~clk;

   lu_scoreboard #(
      .NREG  (NREG),
      .LAT_W (LAT_W),
      .SLOTS (SLOTS)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ins_valid (ins_valid),
      .ins_load  (ins_load),
      .ins_pair  (ins_pair),
      .ins_src_a (ins_src_a),
      .ins_src_b (ins_src_b),
      .ins_dst   (ins_dst),
      .ins_lat   (ins_lat),
      .ret_valid (ret_valid),
      .ret_tag   (ret_tag),
      .stall     (stall)
   );

   function automatic bit busy_m(input int r);
      return tp[r] || (rdy[r] > cyc);
   endfunction

   function automatic int occ_m();
      int n = 0;
      for (int r = 0; r < NREG; r++) if (busy_m(r)) n++;
      return n;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // One clock cycle: drive, compare stall against model, advance model
   task automatic drive(input bit v, input bit ld, input bit pr,
                        input int a, input int b, input int d, input int lat,
                        input bit rv, input int rt, input string req,
                        output bit st);
      int w0, w1, words;
      bit e;
      @(negedge clk);
      ins_valid = v;  ins_load = ld; ins_pair = pr;
      ins_src_a = RW'(a); ins_src_b = RW'(b); ins_dst = RW'(d);
      ins_lat = LAT_W'(lat); ret_valid = rv; ret_tag = RW'(rt);
      w0 = pr ? (d & ~1) : d;
      w1 = d | 1;
      words = pr ? 2 : 1;
      e = v && (busy_m(a) || busy_m(b) || busy_m(w0) || (pr && busy_m(w1)) ||
                (ld && (occ_m() + words > SLOTS)));
      #1;
      chk(stall === e, req, int'(stall), int'(e));
      st = e;
      @(posedge clk);
      if (rv && tp[rt]) tp[rt] = 1'b0;
      if (v && ld && !e) begin
         if (lat == 0) begin
            tp[w0] = 1'b1;
            if (pr) tp[w1] = 1'b1;
         end else begin
            rdy[w0] = cyc + lat;
            if (pr) rdy[w1] = cyc + lat + 1;
         end
      end
      cyc++;
   endtask

   // Present one instruction until it issues; count stall cycles.
   // A return strobe with tag rt is sent in wait cycle ret_at (-1: never).
   task automatic exec(input bit ld, input bit pr, input int a, input int b,
                       input int d, input int lat, input int ret_at, input int rt,
                       input string req, output int stalls);
      bit st;
      stalls = 0;
      for (int i = 0; i < 64; i++) begin
         drive(1'b1, ld, pr, a, b, d, lat, (i == ret_at), rt, req, st);
         if (!st) break;
         stalls++;
      end
   endtask

   // Idle cycles; with flush, sweep a return strobe over every register
   task automatic idle(input int n, input bit flush);
      bit st;
      for (int i = 0; i < n; i++)
         drive(1'b0, 1'b0, 1'b0, 0, 0, 0, 0, flush, i % NREG, "R10", st);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got %0d expected %0d", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int s;
      bit st;
      logic [15:0] lf;
      for (int r = 0; r < NREG; r++) begin rdy[r] = 0; tp[r] = 1'b0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: nothing pending after reset
      for (int r = 0; r < NREG; r++) begin
         drive(1'b1, 1'b0, 1'b0, r, (r + 3) % NREG, r, 0, 1'b0, 0, "R1", st);
         chk(st == 1'b0, "R1", int'(st), 0);
      end

      // R10: no stall while no instruction is presented
      exec(1'b1, 1'b0, 0, 0, 3, 7, -1, 0, "R2", s);
      drive(1'b0, 1'b0, 1'b0, 3, 3, 3, 0, 1'b0, 0, "R10", st);
      chk(stall === 1'b0, "R10", int'(stall), 0);
      idle(16, 1'b1);

      // R2/R3/R4/R5: latency sweep with each dependency kind
      for (int L = 1; L < 8; L++) begin
         for (int k = 0; k < 4; k++) begin
            exec(1'b1, 1'b0, 5, 6, 2, L, -1, 0, "R2", s);
            case (k)
               0: begin exec(1'b0, 1'b0, 2, 0, 1, 0, -1, 0, "R4", s);
                        chk(s == L - 1, "R4", s, L - 1); end
               1: begin exec(1'b0, 1'b0, 0, 2, 1, 0, -1, 0, "R4", s);
                        chk(s == L - 1, "R4", s, L - 1); end
               2: begin exec(1'b0, 1'b0, 0, 1, 2, 0, -1, 0, "R5", s);
                        chk(s == L - 1, "R5", s, L - 1); end
               default: begin exec(1'b0, 1'b0, 0, 1, 3, 0, -1, 0, "R3", s);
                        chk(s == 0, "R3", s, 0); end
            endcase
            idle(16, 1'b1);
         end
      end

      // R5: second load to a register still loading
      exec(1'b1, 1'b0, 0, 1, 4, 5, -1, 0, "R5", s);
      exec(1'b1, 1'b0, 0, 1, 4, 2, -1, 0, "R5", s);
      chk(s == 4, "R5", s, 4);
      idle(16, 1'b1);

      // R6: tagged return after D wait cycles gives D+1 stalls
      for (int D = 0; D < 6; D++) begin
         exec(1'b1, 1'b0, 0, 1, 6, 0, -1, 0, "R6", s);
         exec(1'b0, 1'b0, 6, 1, 2, 0, D, 6, "R6", s);
         chk(s == D + 1, "R6", s, D + 1);
         idle(16, 1'b1);
      end

      // R7: strobe aimed at a counting register does not shorten it
      exec(1'b1, 1'b0, 0, 1, 3, 7, -1, 0, "R7", s);
      exec(1'b0, 1'b0, 3, 1, 2, 0, 0, 3, "R7", s);
      chk(s == 6, "R7", s, 6);
      idle(16, 1'b1);
      // R7: strobe for an idle register leaves a tag wait in place
      exec(1'b1, 1'b0, 0, 1, 6, 0, -1, 0, "R7", s);
      drive(1'b0, 1'b0, 1'b0, 0, 0, 0, 0, 1'b1, 5, "R7", st);
      exec(1'b0, 1'b0, 6, 1, 2, 0, 2, 6, "R7", s);
      chk(s == 3, "R7", s, 3);
      idle(16, 1'b1);

      // R8: pair load, even word L, odd word L+1
      for (int L = 1; L < 7; L++) begin
         exec(1'b1, 1'b1, 0, 1, 5, L, -1, 0, "R8", s);
         exec(1'b0, 1'b0, 4, 1, 2, 0, -1, 0, "R8", s);
         chk(s == L - 1, "R8", s, L - 1);
         idle(16, 1'b1);
         exec(1'b1, 1'b1, 0, 1, 4, L, -1, 0, "R8", s);
         exec(1'b0, 1'b0, 5, 1, 2, 0, -1, 0, "R8", s);
         chk(s == L, "R8", s, L);
         idle(16, 1'b1);
      end
      // R8: tagged pair, each half released separately
      exec(1'b1, 1'b1, 0, 1, 4, 0, -1, 0, "R8", s);
      exec(1'b0, 1'b0, 4, 1, 2, 0, 1, 4, "R8", s);
      chk(s == 2, "R8", s, 2);
      exec(1'b0, 1'b0, 5, 1, 2, 0, 0, 5, "R8", s);
      chk(s == 1, "R8", s, 1);
      idle(16, 1'b1);

      // R9: slot exhaustion by single loads
      exec(1'b1, 1'b0, 0, 0, 1, 7, -1, 0, "R9", s);
      exec(1'b1, 1'b0, 0, 0, 2, 7, -1, 0, "R9", s);
      exec(1'b0, 1'b0, 4, 5, 6, 0, -1, 0, "R3", s);
      chk(s == 0, "R3", s, 0);
      exec(1'b1, 1'b0, 0, 0, 3, 1, -1, 0, "R9", s);
      chk(s == 4, "R9", s, 4);
      idle(16, 1'b1);
      // R9: pair needs two slots
      exec(1'b1, 1'b0, 0, 0, 1, 7, -1, 0, "R9", s);
      exec(1'b1, 1'b1, 0, 0, 4, 1, -1, 0, "R9", s);
      chk(s == 6, "R9", s, 6);
      idle(16, 1'b1);

      // R11: pseudo-random stream against the cycle model
      lf = 16'hACE1;
      for (int n = 0; n < 3000; n++) begin
         bit ld, pr, rv;
         int a, b, d, lat, rt;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         ld  = lf[0] & lf[1];
         pr  = ld & lf[2] & lf[9];
         a   = int'(lf[5:3]);
         b   = int'(lf[8:6]);
         d   = int'(lf[11:9]);
         lat = int'(lf[14:12]);
         for (int i = 0; i < 64; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            rv = lf[0] & lf[4];
            rt = int'(lf[3:1]);
            drive(lf[15] | lf[7], ld, pr, a, b, d, lat, rv, rt, "R11", st);
            if (!st) break;
         end
      end
      idle(16, 1'b1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule